// File: doc/BRIEF.md
# Multi-channel receive DMA with special-character scanning

This block collects received bytes from a set of serial receive channels and moves each one into that channel's own 256-byte ring inside a shared byte buffer. The buffer has a second port through which the host reads the stored data. Several channels can present a byte in the same cycle. An arbiter takes them in rotating order and moves one byte per clock.

Each channel has a 256-bit table of characters that count as special. The value of every byte that is moved selects one bit of its channel's table. When that bit is set, the byte raises a special-character event. The block also raises an event when a ring's fill count reaches a programmed threshold, when a ring fills to its last free slot, and when a byte is flagged as bad or arrives while its ring is full. Events are not driven onto a bare interrupt wire. Each event becomes a record holding the channel number and a 2-bit cause, and the record is queued in a small shared interrupt ring. The host reads the head record, pops it, and clears a sticky flag that marks records lost because the ring was full.

A single register port gives the host access to everything it programs. Through it the host loads the character tables, sets each channel's threshold and event enables, advances each channel's read pointer, and services the interrupt ring.

Top module: `rxscan_dma`

## Requirements
- R1: A byte taken from channel c is written at offset wr_ptr(c) of that channel's ring, and wr_ptr(c) then advances by one modulo 256. The host reads the ring back through buf_rch/buf_ridx, and the byte is readable at the first falling edge after the accepting clock edge.
- R2: When bit (byte mod 32) of table word {c, byte[7:5]} is set, the byte produces a record with cause 1 (special character). The table is written through register kind 0, with the word index in reg_addr[2:0].
- R3: The fill count is wr_ptr minus rd_ptr modulo 256. A threshold event with cause 0 occurs only for the byte that makes the fill count equal the nonzero programmed threshold. Bytes that take the fill count beyond the threshold produce no further threshold event.
- R4: A byte that takes the fill count to 255 produces a limit event with cause 0.
- R5: A byte that arrives while the fill count is 255 is dropped, and wr_ptr stays unchanged. A byte that arrives with rx_err set is still stored. Both cases produce an exception record with cause 2.
- R6: A byte produces at most one record. Where more than one event applies, exception takes priority over special character, and special character takes priority over limit/threshold.
- R7: Each channel has four enables in configuration bits [11:8]: bit 8 special, bit 9 threshold, bit 10 limit, bit 11 exception. An event whose enable is clear produces no record, but the byte is stored all the same.
- R8: Records leave the interrupt ring in the order they entered it. A read of kind 3 returns valid in bit 31, overflow in bit 30, the record count in [23:16], the channel in [15:8] and the cause in [1:0]. A kind 3 write with bit 0 set pops the head record. irq_pending is high whenever the ring holds a record.
- R9: A record that arrives while the interrupt ring holds IRQ_DEPTH records is discarded, and the overflow flag is set. The flag stays set until a kind 3 write with bit 1 set clears it.
- R10: rx_ack grants at most one channel per clock, and only a channel whose rx_valid is high. The search starts at the channel after the last one granted. Three channels requesting at once are therefore granted on three consecutive clocks in rotating order.
- R11: After reset all pointers, thresholds, enables and table words are zero, the interrupt ring is empty, the overflow flag is clear, and irq_pending is low.
- R12: The register address is {kind[1:0], channel, word[2:0]}. A kind 1 write sets the threshold from [7:0] and the enables from [11:8]; its read adds the fill count in [23:16]. A kind 2 write sets rd_ptr from [7:0]; its read returns rd_ptr in [7:0] and wr_ptr in [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | NCH | Per-channel received-byte request, held until acknowledged |
| rx_data | input | NCH*8 | Per-channel received byte, channel c at bits [8c+7:8c] |
| rx_err | input | NCH | Per-channel flag marking the held byte as received with an error |
| rx_ack | output | NCH | One-hot grant; the byte is taken at the clock edge where it is high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | CHW+5 | Register address {kind, channel, word} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| buf_rch | input | CHW | Host buffer read: channel |
| buf_ridx | input | 8 | Host buffer read: offset within the ring |
| buf_rdata | output | 8 | Host buffer read data (combinational) |
| irq_pending | output | 1 | Interrupt ring is not empty |

## Verification
The checker assumes that sources hold rx_valid steady until they are granted. It also assumes that a pop is written to the interrupt ring only when the ring holds a record, so that irq_pending can only fall after a pop request. The bench drives every request at a falling edge and, in the single-channel task, drops it one clock later, after the grant. It pops only after it has read a valid head record, so no stimulus takes the block outside these assumptions. Bytes are sent on one channel at a time, except in the arbitration test, which raises three requests at once.

// File: rtl/rxscan_pkg.sv
// Shared types for the scanning receive DMA.
// Assumes nothing beyond a 2-bit cause field in every interrupt record.
package rxscan_pkg;

    // Cause codes carried in each interrupt record.
    typedef enum logic [1:0] {
        CAUSE_LIMTHR  = 2'd0,
        CAUSE_SPECIAL = 2'd1,
        CAUSE_EXCEPT  = 2'd2,
        CAUSE_RSVD    = 2'd3
    } irq_cause_e;

    // Register kinds selected by the top two address bits.
    typedef enum logic [1:0] {
        KIND_MAP = 2'd0,
        KIND_CFG = 2'd1,
        KIND_PTR = 2'd2,
        KIND_IRQ = 2'd3
    } reg_kind_e;

    // Bit positions inside the per-channel 4-bit enable field.
    localparam int EN_SPEC = 0;
    localparam int EN_THR  = 1;
    localparam int EN_LIM  = 2;
    localparam int EN_EXC  = 3;

endpackage

// File: rtl/rxscan_rr_arb.sv
// Rotating-priority arbiter: grants one requester per clock, and the search
// starts just after the last requester granted.
// Assumes requests stay up until granted; N >= 2.
module rxscan_rr_arb #(
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] gnt_idx,
    output logic                 gnt_any
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] last;

    // Pick the first requester at or after last+1, wrapping around.
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int i = 0; i < N; i++) begin
            int c;
            c = (int'(last) + 1 + i) % N;
            if (!gnt_any && req[c]) begin
                gnt_any = 1'b1;
                gnt_idx = IW'(c);
                gnt[c]  = 1'b1;
            end
        end
    end

    // Remember the channel served, so the next search starts after it.
    always_ff @(posedge clk) begin
        if (!rst_n)       last <= IW'(N - 1);
        else if (gnt_any) last <= gnt_idx;
    end
endmodule

// File: rtl/rxscan_bitmap.sv
// Per-channel 256-bit special-character tables, stored as 8 words of 32 bits
// for each channel. One combinational lookup port serves the DMA side; one
// write port and one read port serve the host.
// Assumes a host write and a lookup never need ordering within a single cycle.
module rxscan_bitmap #(
    parameter int NCH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NCH)+2:0]   wr_addr,
    input  logic [31:0]              wr_data,
    input  logic [$clog2(NCH)+2:0]   rd_addr,
    output logic [31:0]              rd_data,
    input  logic [$clog2(NCH)-1:0]   look_ch,
    input  logic [7:0]               look_byte,
    output logic                     look_hit
);
    localparam int CHW   = $clog2(NCH);
    localparam int WORDS = NCH * 8;

    logic [31:0] mem [WORDS];
    logic [CHW+2:0] look_addr;

    // Table storage: cleared by reset, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Lookup: the byte's top three bits pick the word, the low five the bit.
    always_comb begin
        look_addr = {look_ch, look_byte[7:5]};
        look_hit  = mem[look_addr][look_byte[4:0]];
        rd_data   = mem[rd_addr];
    end
endmodule

// File: rtl/rxscan_rxbuf.sv
// Dual-ported byte buffer holding one 256-byte ring per channel.
// The DMA writes through the synchronous port; the host reads combinationally.
// Assumes the contents need no reset.
module rxscan_rxbuf #(
    parameter int NCH = 16
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [$clog2(NCH)+7:0] waddr,
    input  logic [7:0]             wdata,
    input  logic [$clog2(NCH)+7:0] raddr,
    output logic [7:0]             rdata
);
    localparam int BYTES = NCH * 256;

    logic [7:0] mem [BYTES];

    // DMA write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Host read port.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/rxscan_irqq.sv
// Shared interrupt-record ring. When full it discards new records and sets a
// sticky overflow flag; a record arriving in the same cycle as a pop is still
// discarded when the ring is full.
// Assumes pop is requested only while a record is present (it is ignored otherwise).
module rxscan_irqq #(
    parameter int DEPTH = 8,
    parameter int W     = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    input  logic                       clr_ovf,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          full, do_push, do_pop;

    // Push and pop qualification.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem[rp];
    end

    // Ring storage, pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Sticky overflow: setting it wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)              ovf <= 1'b0;
        else if (push && full)   ovf <= 1'b1;
        else if (clr_ovf)        ovf <= 1'b0;
    end
endmodule

// File: rtl/rxscan_dma.sv
// Multi-channel receive DMA with special-character scanning.
// Serves one received byte per clock in rotating order. It stores the byte in
// that channel's ring, tests the byte against the channel's character table,
// checks the fill threshold, the full limit and error conditions, and queues at
// most one cause-coded record per byte.
// Assumes sources hold rx_valid/rx_data/rx_err steady until rx_ack.
module rxscan_dma
    import rxscan_pkg::*;
#(
    parameter int NCH       = 16,
    parameter int IRQ_DEPTH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          rx_valid,
    input  logic [NCH*8-1:0]        rx_data,
    input  logic [NCH-1:0]          rx_err,
    output logic [NCH-1:0]          rx_ack,
    input  logic                    reg_we,
    input  logic [$clog2(NCH)+4:0]  reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    input  logic [$clog2(NCH)-1:0]  buf_rch,
    input  logic [7:0]              buf_ridx,
    output logic [7:0]              buf_rdata,
    output logic                    irq_pending
);
    localparam int CHW  = $clog2(NCH);
    localparam int RA_W = CHW + 5;
    localparam int RECW = CHW + 2;
    localparam int QCW  = $clog2(IRQ_DEPTH + 1);

    // Per-channel state.
    logic [7:0] wr_ptr [NCH];
    logic [7:0] rd_ptr [NCH];
    logic [7:0] thr    [NCH];
    logic [3:0] en     [NCH];

    // Arbiter outputs and the selected byte.
    logic [NCH-1:0] gnt;
    logic [CHW-1:0] gch;
    logic           gany;
    logic [7:0]     gbyte;
    logic           gerr;

    // Event evaluation.
    logic [7:0]  fill_now, fill_new;
    logic        ring_full, store, hit;
    logic        ev_exc, ev_spec, ev_thr, ev_lim;
    logic        post;
    irq_cause_e  post_cause;

    // Host decode.
    reg_kind_e      kind;
    logic [CHW-1:0] rch;
    logic           map_we, cfg_we, ptr_we, q_pop, q_clr;

    // Interrupt ring outputs.
    logic [RECW-1:0] q_dout;
    logic            q_empty, q_ovf;
    logic [QCW-1:0]  q_count;
    logic [7:0]      fill_rd;
    logic [31:0]     map_rdata;

    rxscan_rr_arb #(.N(NCH)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(rx_valid),
        .gnt(gnt), .gnt_idx(gch), .gnt_any(gany)
    );

    assign rx_ack = gnt;

    // Select the granted channel's byte and error flag.
    always_comb begin
        gbyte = rx_data[gch*8 +: 8];
        gerr  = rx_err[gch];
    end

    // Work out the events this byte raises and the one record it posts.
    always_comb begin
        fill_now  = wr_ptr[gch] - rd_ptr[gch];
        fill_new  = fill_now + 8'd1;
        ring_full = (fill_now == 8'hFF);
        store     = gany && !ring_full;
        ev_exc    = gerr || ring_full;
        ev_spec   = hit && !ring_full;
        ev_thr    = !ring_full && (thr[gch] != 8'd0) && (fill_new == thr[gch]);
        ev_lim    = !ring_full && (fill_new == 8'hFF);
        post       = 1'b0;
        post_cause = CAUSE_LIMTHR;
        if (ev_exc && en[gch][EN_EXC]) begin
            post       = gany;
            post_cause = CAUSE_EXCEPT;
        end else if (ev_spec && en[gch][EN_SPEC]) begin
            post       = gany;
            post_cause = CAUSE_SPECIAL;
        end else if ((ev_thr && en[gch][EN_THR]) || (ev_lim && en[gch][EN_LIM])) begin
            post       = gany;
            post_cause = CAUSE_LIMTHR;
        end
    end

    rxscan_bitmap #(.NCH(NCH)) u_map (
        .clk(clk), .rst_n(rst_n),
        .wr_en(map_we), .wr_addr({rch, reg_addr[2:0]}), .wr_data(reg_wdata),
        .rd_addr({rch, reg_addr[2:0]}), .rd_data(map_rdata),
        .look_ch(gch), .look_byte(gbyte), .look_hit(hit)
    );

    rxscan_rxbuf #(.NCH(NCH)) u_buf (
        .clk(clk), .we(store), .waddr({gch, wr_ptr[gch]}), .wdata(gbyte),
        .raddr({buf_rch, buf_ridx}), .rdata(buf_rdata)
    );

    rxscan_irqq #(.DEPTH(IRQ_DEPTH), .W(RECW)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .push(post), .din({gch, post_cause}),
        .pop(q_pop), .clr_ovf(q_clr),
        .dout(q_dout), .empty(q_empty), .count(q_count), .ovf(q_ovf)
    );

    assign irq_pending = !q_empty;

    // Host address decode into per-kind strobes.
    always_comb begin
        kind    = reg_kind_e'(reg_addr[RA_W-1 -: 2]);
        rch     = reg_addr[3 +: CHW];
        map_we  = reg_we && (kind == KIND_MAP);
        cfg_we  = reg_we && (kind == KIND_CFG);
        ptr_we  = reg_we && (kind == KIND_PTR);
        q_pop   = reg_we && (kind == KIND_IRQ) && reg_wdata[0];
        q_clr   = reg_we && (kind == KIND_IRQ) && reg_wdata[1];
        fill_rd = wr_ptr[rch] - rd_ptr[rch];
    end

    // Host read mux.
    always_comb begin
        case (kind)
            KIND_MAP: reg_rdata = map_rdata;
            KIND_CFG: reg_rdata = {8'd0, fill_rd, 4'd0, en[rch], thr[rch]};
            KIND_PTR: reg_rdata = {16'd0, wr_ptr[rch], rd_ptr[rch]};
            default:  reg_rdata = {!q_empty, q_ovf, 6'd0, 8'(q_count),
                                   8'(q_dout[RECW-1:2]), 6'd0, q_dout[1:0]};
        endcase
    end

    // Write pointers: advanced by the DMA side only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) wr_ptr[i] <= '0;
        end else if (store) begin
            wr_ptr[gch] <= wr_ptr[gch] + 8'd1;
        end
    end

    // Host-owned per-channel registers: read pointer, threshold, enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                rd_ptr[i] <= '0;
                thr[i]    <= '0;
                en[i]     <= '0;
            end
        end else begin
            if (ptr_we) rd_ptr[rch] <= reg_wdata[7:0];
            if (cfg_we) begin
                thr[rch] <= reg_wdata[7:0];
                en[rch]  <= reg_wdata[11:8];
            end
        end
    end
endmodule

// File: rtl/rxscan_chk.sv
// Assertion checker for rxscan_dma, bound to every instance.
// Assumes sources hold requests until granted and the host pops only a
// non-empty interrupt ring.
module rxscan_chk #(
    parameter int NCH       = 16,
    parameter int IRQ_DEPTH = 8,
    parameter int QCW       = 4,
    parameter int RA_W      = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   rx_valid,
    input logic [NCH-1:0]   rx_ack,
    input logic             irq_pending,
    input logic             reg_we,
    input logic [RA_W-1:0]  reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [QCW-1:0]   q_count,
    input logic             q_ovf
);
    logic irq_wr;
    assign irq_wr = reg_we && (reg_addr[RA_W-1 -: 2] == 2'd3);

    // R10
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_ack));

    // R10
    ack_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack & ~rx_valid) == '0);

    // R9
    ring_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= QCW'(IRQ_DEPTH));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_ovf && !(irq_wr && reg_wdata[1])) |=> q_ovf);

    // R8
    pending_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pending) |-> $past(|rx_ack));

    // R8
    pending_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_pending) |-> $past(irq_wr && reg_wdata[0]));
endmodule

bind rxscan_dma rxscan_chk #(
    .NCH(NCH), .IRQ_DEPTH(IRQ_DEPTH), .QCW(QCW), .RA_W(RA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ack(rx_ack),
    .irq_pending(irq_pending), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .q_count(q_count), .q_ovf(q_ovf)
);

// File: tb/tb_rxscan_dma.sv
// Self-checking bench for rxscan_dma: a vector table walked by one loop, then
// directed tests for reset, limit/overrun, ring overflow and arbitration.
module tb_rxscan_dma;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int DEP = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    rx_valid = '0;
    logic [NCH*8-1:0]  rx_data = '0;
    logic [NCH-1:0]    rx_err = '0;
    logic [NCH-1:0]    rx_ack;
    logic              reg_we = 1'b0;
    logic [8:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [3:0]        buf_rch = '0;
    logic [7:0]        buf_ridx = '0;
    logic [7:0]        buf_rdata;
    logic              irq_pending;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int exp_wr [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxscan_dma #(.NCH(NCH), .IRQ_DEPTH(DEP)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_err(rx_err), .rx_ack(rx_ack), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_rch(buf_rch),
        .buf_ridx(buf_ridx), .buf_rdata(buf_rdata), .irq_pending(irq_pending)
    );

    // Vector: [15:12] ch, [11:4] byte, [3] err, [2] record expected, [1:0] cause.
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {4'd0, 8'h30, 1'b0, 1'b0, 2'd0},  // below threshold, no record
        {4'd0, 8'h41, 1'b0, 1'b1, 2'd1},  // R2 special
        {4'd0, 8'h31, 1'b0, 1'b1, 2'd0},  // R3 fill reaches 3
        {4'd0, 8'h32, 1'b0, 1'b0, 2'd0},  // R3 no repeat
        {4'd0, 8'h0D, 1'b0, 1'b1, 2'd1},  // R2 second table bit
        {4'd0, 8'h33, 1'b1, 1'b1, 2'd2},  // R5 error byte
        {4'd1, 8'h41, 1'b0, 1'b0, 2'd0},  // R2 other channel's table empty
        {4'd0, 8'h41, 1'b1, 1'b1, 2'd2},  // R6 exception over special
        {4'd1, 8'h37, 1'b1, 1'b1, 2'd2},  // R5 error on ch1
        {4'd3, 8'h41, 1'b0, 1'b1, 2'd1},  // R6 special over threshold
        {4'd3, 8'h42, 1'b0, 1'b0, 2'd0},  // R3 past threshold
        {4'd4, 8'h41, 1'b1, 1'b0, 2'd0}   // R7 all enables clear
    };

    function automatic logic [8:0] ra(int kind, int ch, int word);
        return {kind[1:0], ch[3:0], word[2:0]};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [8:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic brd(int ch, int idx, output logic [7:0] d);
        buf_rch = ch[3:0]; buf_ridx = idx[7:0];
        #1;
        d = buf_rdata;
    endtask

    task automatic send(int ch, logic [7:0] d, logic e);
        @(negedge clk);
        rx_valid[ch] = 1'b1; rx_data[ch*8 +: 8] = d; rx_err[ch] = e;
        @(negedge clk);
        rx_valid[ch] = 1'b0; rx_err[ch] = 1'b0;
    endtask

    task automatic pop();
        wr(ra(3, 0, 0), 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  b;
        for (int i = 0; i < NCH; i++) exp_wr[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11", "irq_pending", 32'(irq_pending), 0);
        chk("R11", "rx_ack idle", 32'(rx_ack), 0);
        rd(ra(3, 0, 0), r); chk("R11", "irq head", r, 0);
        rd(ra(1, 5, 0), r); chk("R11", "cfg ch5", r, 0);
        rd(ra(2, 5, 0), r); chk("R11", "ptr ch5", r, 0);
        rd(ra(0, 5, 2), r); chk("R11", "table ch5", r, 0);

        // Setup: tables and configuration (R12 register map).
        wr(ra(0, 0, 2), 32'h2);       // ch0: 0x41
        wr(ra(0, 0, 0), 32'h2000);    // ch0: 0x0D
        wr(ra(0, 3, 2), 32'h2);       // ch3: 0x41
        wr(ra(0, 4, 2), 32'h2);       // ch4: 0x41
        wr(ra(1, 0, 0), 32'h0F03);    // ch0: all enables, threshold 3
        wr(ra(1, 1, 0), 32'h0F00);    // ch1: all enables, no threshold
        wr(ra(1, 3, 0), 32'h0F01);    // ch3: all enables, threshold 1
        wr(ra(1, 4, 0), 32'h0001);    // ch4: no enables
        rd(ra(1, 0, 0), r); chk("R12", "cfg readback", r, 32'h0F03);
        rd(ra(0, 0, 0), r); chk("R2", "table readback", r, 32'h2000);

        // Vector table walk (R1 R2 R3 R5 R6 R7 R8).
        for (int v = 0; v < NV; v++) begin
            int ch;
            ch = int'(VEC[v][15:12]);
            send(ch, VEC[v][11:4], VEC[v][3]);
            brd(ch, exp_wr[ch], b);
            chk("R1", $sformatf("vec %0d stored byte", v), 32'(b), 32'(VEC[v][11:4]));
            exp_wr[ch]++;
            rd(ra(3, 0, 0), r);
            chk("R8", $sformatf("vec %0d record valid", v), 32'(r[31]), 32'(VEC[v][2]));
            if (VEC[v][2]) begin
                chk("R8", $sformatf("vec %0d channel", v), 32'(r[15:8]), 32'(ch));
                chk("R6", $sformatf("vec %0d cause", v), 32'(r[1:0]), 32'(VEC[v][1:0]));
                pop();
            end
        end
        rd(ra(2, 0, 0), r); chk("R12", "ch0 wr_ptr", 32'(r[15:8]), 7);

        // Limit and overrun on ch2: limit + exception enabled (R4 R5).
        wr(ra(1, 2, 0), 32'h0C00);
        for (int i = 0; i < 254; i++) send(2, 8'(i) ^ 8'h5A, 1'b0);
        chk("R4", "no record before limit", 32'(irq_pending), 0);
        send(2, 8'(254) ^ 8'h5A, 1'b0);
        rd(ra(3, 0, 0), r);
        chk("R4", "limit record", {r[31], 15'd0, r[15:8], 6'd0, r[1:0]}, 32'h8000_0200);
        pop();
        rd(ra(2, 2, 0), r); chk("R4", "wr_ptr at limit", 32'(r[15:8]), 255);
        send(2, 8'h77, 1'b0);
        rd(ra(3, 0, 0), r);
        chk("R5", "overrun record", {r[31], 15'd0, r[15:8], 6'd0, r[1:0]}, 32'h8000_0202);
        pop();
        rd(ra(2, 2, 0), r); chk("R5", "wr_ptr held on drop", 32'(r[15:8]), 255);
        brd(2, 254, b); chk("R5", "last stored byte kept", 32'(b), 32'(8'(254) ^ 8'h5A));
        wr(ra(2, 2, 0), 32'd10);
        rd(ra(1, 2, 0), r); chk("R12", "fill after rd_ptr write", 32'(r[23:16]), 245);
        send(2, 8'hEE, 1'b0);
        chk("R3", "no record below limit", 32'(irq_pending), 0);
        brd(2, 255, b); chk("R1", "ring slot 255", 32'(b), 32'hEE);
        rd(ra(2, 2, 0), r); chk("R1", "wr_ptr wraps", 32'(r[15:8]), 0);

        // Interrupt ring overflow (R9).
        for (int i = 0; i < 10; i++) send(0, 8'h41, 1'b0);
        rd(ra(3, 0, 0), r);
        chk("R9", "count at depth", 32'(r[23:16]), DEP);
        chk("R9", "overflow set", 32'(r[30]), 1);
        chk("R8", "head of full ring", {r[15:8], 6'd0, r[1:0]}, 16'h0001);
        wr(ra(3, 0, 0), 32'h2);
        rd(ra(3, 0, 0), r);
        chk("R9", "overflow cleared", 32'(r[30]), 0);
        chk("R9", "count kept by clear", 32'(r[23:16]), DEP);
        for (int i = 0; i < DEP; i++) pop();
        chk("R8", "pending after drain", 32'(irq_pending), 0);

        // Rotating arbitration (R10): last grant ch7, then 2, 6, 9 at once.
        send(7, 8'h07, 1'b0);
        @(negedge clk);
        rx_data[2*8 +: 8] = 8'hA2; rx_data[6*8 +: 8] = 8'hA6; rx_data[9*8 +: 8] = 8'hA9;
        rx_valid[2] = 1'b1; rx_valid[6] = 1'b1; rx_valid[9] = 1'b1;
        begin
            int order [3] = '{9, 2, 6};
            for (int k = 0; k < 3; k++) begin
                #1;
                chk("R10", $sformatf("grant %0d", k), 32'(rx_ack), 32'(1) << order[k]);
                @(negedge clk);
                rx_valid[order[k]] = 1'b0;
            end
        end
        #1;
        chk("R10", "no grant after", 32'(rx_ack), 0);
        brd(9, 0, b); chk("R10", "ch9 byte", 32'(b), 32'hA9);
        brd(6, 0, b); chk("R10", "ch6 byte", 32'(b), 32'hA6);
        brd(2, 0, b); chk("R10", "ch2 byte", 32'(b), 32'hA2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule